// File: doc/BRIEF.md
# Next-PC and Branch Unit

This block holds the program counter of a 32-bit RISC core whose instructions are always four bytes long, and it works out the address of the next fetch in every cycle. The decoder supplies a branch-condition code, flags for a PC-relative jump, a register-indirect jump and a halt-loop instruction, the two register operands and a sign-extended immediate. From these the block selects between the sequential address, a branch or jump target, and the current PC. It also returns the link value that a jump writes back, a taken flag and a fault flag for a next fetch address that is not word aligned.

The PC register loads the selected next address on every rising clock edge. One instruction is retired per cycle. All other outputs are combinational functions of the current PC and the inputs of that cycle.

Top module: `nextpc_unit`

## Requirements
- R1: While rst_ni is low and after it is released, pc_o equals START_ADDR (default 0) until the first rising edge with rst_ni high.
- R2: With no jump, no halt and no condition met, next_pc_o is pc_o + 4 and taken_o is 0. This covers a no-operation instruction and br_kind_i value 0 (none) or 7 (reserved, treated as none). pc_o takes the value of next_pc_o at the next rising edge.
- R3: br_kind_i selects a compare of rs1_i against rs2_i: 1 equal, 2 not equal, 3 signed less-than, 4 signed greater-or-equal, 5 unsigned less-than, 6 unsigned greater-or-equal. When the compare holds, next_pc_o is pc_o + imm_i and taken_o is 1. Otherwise R2 applies.
- R4: When jal_i is 1, next_pc_o is pc_o + imm_i and taken_o is 1.
- R5: When jalr_i is 1, next_pc_o is rs1_i + imm_i with bit 0 forced to 0, and taken_o is 1.
- R6: link_o is always pc_o + 4.
- R7: When halt_i is 1, next_pc_o equals pc_o and taken_o is 1, so the PC stays where it is.
- R8: fault_o is 1 in the same cycle exactly when bits 1:0 of next_pc_o are not both zero.
- R9: The sources of the next PC have a fixed priority: halt_i first, then jalr_i, then jal_i, then a met branch condition, then the sequential address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| br_kind_i | input | 3 | Branch condition code (see R3) |
| jal_i | input | 1 | PC-relative jump |
| jalr_i | input | 1 | Register-indirect jump |
| halt_i | input | 1 | Halt-loop instruction |
| rs1_i | input | 32 | First register operand |
| rs2_i | input | 32 | Second register operand |
| imm_i | input | 32 | Sign-extended immediate |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address of the next fetch |
| link_o | output | 32 | Return address for jumps |
| taken_o | output | 1 | Control flow leaves the sequential path |
| fault_o | output | 1 | Next fetch address is misaligned |

## Verification
The outputs next_pc_o, link_o, taken_o and fault_o are due in the same cycle as the inputs and the current PC. The bench therefore applies each vector just after a rising edge and samples 1 ns later, before the falling edge. pc_o is due one edge later, so the register checks sample 1 ns after the edge that follows a stimulus. To place the PC at an arbitrary address before each vector, the bench applies a register-indirect jump to that address and waits one edge.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_EQ   = 3'd1,
    BR_NE   = 3'd2,
    BR_LT   = 3'd3,
    BR_GE   = 3'd4,
    BR_LTU  = 3'd5,
    BR_GEU  = 3'd6,
    BR_RSV  = 3'd7
  } br_kind_e;
endpackage

// File: rtl/nextpc_cmp.sv
module nextpc_cmp
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e          kind_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  output logic              cond_o
);
  logic eq, lt, ltu;

  assign eq  = (a_i == b_i);
  assign lt  = ($signed(a_i) < $signed(b_i));
  assign ltu = (a_i < b_i);

  always_comb begin
    case (kind_i)
      BR_EQ:   cond_o = eq;
      BR_NE:   cond_o = !eq;
      BR_LT:   cond_o = lt;
      BR_GE:   cond_o = !lt;
      BR_LTU:  cond_o = ltu;
      BR_GEU:  cond_o = !ltu;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nextpc_sel.sv
module nextpc_sel #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            cond_i,
  input  logic            jal_i,
  input  logic            jalr_i,
  input  logic            halt_i,
  output logic [XLEN-1:0] next_o,
  output logic [XLEN-1:0] seq_o,
  output logic            taken_o
);
  logic [XLEN-1:0] rel_tgt, ind_sum, ind_tgt;

  assign seq_o   = pc_i + XLEN'(STEP);
  assign rel_tgt = pc_i + imm_i;
  assign ind_sum = rs1_i + imm_i;
  assign ind_tgt = {ind_sum[XLEN-1:1], 1'b0};

  // fixed priority: halt, indirect, direct, branch, sequential
  always_comb begin
    taken_o = 1'b1;
    if (halt_i)      next_o = pc_i;
    else if (jalr_i) next_o = ind_tgt;
    else if (jal_i)  next_o = rel_tgt;
    else if (cond_i) next_o = rel_tgt;
    else begin
      next_o  = seq_o;
      taken_o = 1'b0;
    end
  end
endmodule

// File: rtl/nextpc_reg.sv
module nextpc_reg #(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] START_ADDR = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= START_ADDR;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              ILEN_BYTES = 4,
  parameter logic [XLEN-1:0] START_ADDR = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      br_kind_i,
  input  logic            jal_i,
  input  logic            jalr_i,
  input  logic            halt_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o,
  output logic            taken_o,
  output logic            fault_o
);
  localparam int ALIGN_BITS = $clog2(ILEN_BYTES);

  logic cond;

  nextpc_cmp #(.XLEN(XLEN)) u_cmp (
    .kind_i (br_kind_e'(br_kind_i)),
    .a_i    (rs1_i),
    .b_i    (rs2_i),
    .cond_o (cond)
  );

  nextpc_sel #(.XLEN(XLEN), .STEP(ILEN_BYTES)) u_sel (
    .pc_i    (pc_o),
    .rs1_i   (rs1_i),
    .imm_i   (imm_i),
    .cond_i  (cond),
    .jal_i   (jal_i),
    .jalr_i  (jalr_i),
    .halt_i  (halt_i),
    .next_o  (next_pc_o),
    .seq_o   (link_o),
    .taken_o (taken_o)
  );

  nextpc_reg #(.XLEN(XLEN), .START_ADDR(START_ADDR)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (next_pc_o),
    .q_o    (pc_o)
  );

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign fault_o = |next_pc_o[ALIGN_BITS-1:0];
    end else begin : g_noalign
      assign fault_o = 1'b0;
    end
  endgenerate

  // R7
  a_r7_halt_spin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> (next_pc_o == pc_o) && taken_o);

  // R6
  a_r6_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jal_i || jalr_i) |-> (link_o == pc_o + XLEN'(ILEN_BYTES)));

  // R2
  a_r2_sequential: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_i && !jal_i && !jalr_i && (br_kind_i == 3'd0 || br_kind_i == 3'd7))
      |-> (next_pc_o == pc_o + XLEN'(ILEN_BYTES)) && !taken_o);

  // R2: PC follows the selected address
  a_r2_pc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pc_o == $past(next_pc_o)));

  // R5
  a_r5_ind_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jalr_i && !halt_i) |-> !next_pc_o[0] && taken_o);

  // R3: equal operands never take a not-equal branch
  a_r3_ne_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_kind_i == 3'd2 && rs1_i == rs2_i && !halt_i && !jal_i && !jalr_i) |-> !taken_o);

  // R8
  a_r8_aligned_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |=> (pc_o[1:0] == 2'b00));
endmodule

// File: tb/nextpc_unit_tb.sv
`timescale 1ns/1ps
module nextpc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  br_kind = '0;
  logic        jal = 1'b0, jalr = 1'b0, halt = 1'b0;
  logic [31:0] rs1 = '0, rs2 = '0, imm = '0;
  logic [31:0] pc, next_pc, link;
  logic        taken, fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  nextpc_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .br_kind_i(br_kind), .jal_i(jal),
    .jalr_i(jalr), .halt_i(halt), .rs1_i(rs1), .rs2_i(rs2), .imm_i(imm),
    .pc_o(pc), .next_pc_o(next_pc), .link_o(link), .taken_o(taken),
    .fault_o(fault)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] pc;
    logic [2:0]  kind;
    logic        jal;
    logic        jalr;
    logic        halt;
    logic [31:0] rs1;
    logic [31:0] rs2;
    logic [31:0] imm;
    logic [31:0] nxt;
    logic        tkn;
    logic        flt;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{8'd2, 32'h100, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h40, 32'h104, 1'b0, 1'b0},        // R2
    '{8'd3, 32'h100, 3'd1, 1'b0, 1'b0, 1'b0, 32'h5, 32'h5, 32'h40, 32'h140, 1'b1, 1'b0},        // R3 eq
    '{8'd3, 32'h100, 3'd1, 1'b0, 1'b0, 1'b0, 32'h5, 32'h6, 32'h40, 32'h104, 1'b0, 1'b0},
    '{8'd3, 32'h200, 3'd2, 1'b0, 1'b0, 1'b0, 32'h5, 32'h6, 32'hFFFFFFF8, 32'h1F8, 1'b1, 1'b0},  // R3 ne backward
    '{8'd3, 32'h200, 3'd2, 1'b0, 1'b0, 1'b0, 32'h7, 32'h7, 32'hFFFFFFF8, 32'h204, 1'b0, 1'b0},
    '{8'd3, 32'h300, 3'd3, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h10, 32'h310, 1'b1, 1'b0}, // R3 lt signed
    '{8'd3, 32'h300, 3'd5, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h10, 32'h304, 1'b0, 1'b0}, // R3 ltu
    '{8'd3, 32'h300, 3'd4, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h10, 32'h304, 1'b0, 1'b0}, // R3 ge
    '{8'd3, 32'h300, 3'd6, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h1, 32'h10, 32'h310, 1'b1, 1'b0}, // R3 geu
    '{8'd3, 32'h300, 3'd4, 1'b0, 1'b0, 1'b0, 32'h3, 32'h3, 32'h20, 32'h320, 1'b1, 1'b0},        // R3 ge equal
    '{8'd3, 32'h300, 3'd5, 1'b0, 1'b0, 1'b0, 32'h3, 32'h3, 32'h20, 32'h304, 1'b0, 1'b0},        // R3 ltu equal
    '{8'd4, 32'h400, 3'd0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 32'h800, 32'hC00, 1'b1, 1'b0},       // R4
    '{8'd5, 32'h400, 3'd0, 1'b0, 1'b1, 1'b0, 32'h1001, 32'h0, 32'h10, 32'h1010, 1'b1, 1'b0},    // R5 lsb cleared
    '{8'd8, 32'h400, 3'd0, 1'b0, 1'b1, 1'b0, 32'h1000, 32'h0, 32'h2, 32'h1002, 1'b1, 1'b1},     // R8 via indirect
    '{8'd7, 32'h400, 3'd1, 1'b1, 1'b0, 1'b1, 32'h1, 32'h1, 32'h800, 32'h400, 1'b1, 1'b0},       // R7 over jal/branch
    '{8'd2, 32'h500, 3'd7, 1'b0, 1'b0, 1'b0, 32'h1, 32'h1, 32'h40, 32'h504, 1'b0, 1'b0},        // R2 reserved code
    '{8'd8, 32'h500, 3'd1, 1'b0, 1'b0, 1'b0, 32'h1, 32'h1, 32'h6, 32'h506, 1'b1, 1'b1},         // R8 via branch
    '{8'd9, 32'h500, 3'd0, 1'b1, 1'b1, 1'b0, 32'h2000, 32'h0, 32'h4, 32'h2004, 1'b1, 1'b0},     // R9 jalr over jal
    '{8'd3, 32'h300, 3'd3, 1'b0, 1'b0, 1'b0, 32'h1, 32'h80000000, 32'h10, 32'h304, 1'b0, 1'b0}  // R3 lt, negative rs2
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    br_kind = 3'd0; jal = 1'b0; jalr = 1'b0; halt = 1'b0;
    rs1 = '0; rs2 = '0; imm = '0;
  endtask

  // place PC at p via an indirect jump; returns 1 ns after the loading edge
  task automatic steer(input logic [31:0] p);
    @(negedge clk);
    clear_in();
    jalr = 1'b1; rs1 = p;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    chk("R1", "pc in reset", pc, 32'h0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "pc held in reset", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "pc after release", pc, 32'h0);
    chk("R2", "next from start", next_pc, 32'h4);

    // R2: sequential advance through the register
    @(posedge clk); #1;
    chk("R2", "pc after one edge", pc, 32'h4);
    @(posedge clk); #1;
    chk("R2", "pc after two edges", pc, 32'h8);

    // vector table
    for (int i = 0; i < NV; i++) begin
      string rq;
      steer(VECS[i].pc);
      rq = $sformatf("R%0d", VECS[i].req);
      chk(rq, "steered pc", pc, VECS[i].pc);
      br_kind = VECS[i].kind; jal = VECS[i].jal; jalr = VECS[i].jalr;
      halt = VECS[i].halt; rs1 = VECS[i].rs1; rs2 = VECS[i].rs2; imm = VECS[i].imm;
      #1;
      chk(rq, $sformatf("v%0d next", i), next_pc, VECS[i].nxt);
      chk(rq, $sformatf("v%0d taken", i), {31'b0, taken}, {31'b0, VECS[i].tkn});
      chk(rq, $sformatf("v%0d fault", i), {31'b0, fault}, {31'b0, VECS[i].flt});
      chk("R6", $sformatf("v%0d link", i), link, VECS[i].pc + 32'd4);
    end

    // R4: jump target is loaded into the PC
    steer(32'h400);
    jalr = 1'b0; jal = 1'b1; imm = 32'h800;
    @(posedge clk); #1;
    chk("R4", "pc after jump", pc, 32'hC00);

    // R7: halt keeps the PC fixed over several edges
    clear_in();
    halt = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7", "pc spins", pc, 32'hC00);
    chk("R7", "next during spin", next_pc, 32'hC00);

    // R8: misaligned PC from an indirect jump, then sequential fault
    steer(32'h402);
    chk("R8", "pc misaligned", pc, 32'h402);
    clear_in();
    #1;
    chk("R8", "seq next", next_pc, 32'h406);
    chk("R8", "fault on seq", {31'b0, fault}, 32'h1);

    // R8: aligned next gives no fault
    steer(32'h600);
    clear_in();
    #1;
    chk("R8", "no fault aligned", {31'b0, fault}, 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule